// File: doc/BRIEF.md
# LIN Transmit Path Controller

This block is the digital control that sits between a host and a LIN bus transceiver. The host supplies a transmit level and an enable level, and a timebase supplies a periodic one-cycle tick. The block turns these into a driver-enable output and a receive output. When the driver enable is high, the bus is pulled to the dominant (low) level. The receive output reports the level of the bus comparator back to the host.

After reset the block sits in a fail-safe mode. In this mode the driver is kept off and the receive output is held high. Raising the enable input selects normal mode. In normal mode a low transmit level switches the driver on and a high level switches it off. Both host inputs are synchronised to the system clock before they are used.

A dominant watchdog counts timebase ticks while the host asks for a dominant bus. When the count reaches the limit, the driver is forced off and a time-out flag is raised. Both stay that way until the transmit input goes back high, which re-arms the watchdog. A build parameter removes the watchdog so that the bus can be held dominant for any length of time, which suits very low data rates.

Top module: `lin_tx_ctrl`

## Requirements
- R1: After reset the block is in fail-safe mode, with `drv_on` low, `rx_out` high and `timeout_flag` low.
- R2: In normal mode, with no time-out pending, `drv_on` is the inverse of the synchronised `tx_in`: transmit 0 gives driver on (dominant), and transmit 1 gives driver off (recessive).
- R3: In fail-safe mode `drv_on` stays low and `rx_out` stays high, whatever the values of `tx_in` and `bus_in`.
- R4: In normal mode `rx_out` equals `bus_in`, where 1 means recessive and 0 means dominant.
- R5: The mode follows `en_in` after synchronisation. `en_in` = 1 selects normal mode and `en_in` = 0 returns the block to fail-safe mode.
- R6: With the time-out built in (`TIMEOUT_EN` = 1), in normal mode with `tx_in` held low, the `TIMEOUT_TICKS`-th `tick` pulse forces `drv_on` low and sets `timeout_flag` on the next clock edge. Before that pulse, `drv_on` stays high.
- R7: After a time-out, `drv_on` stays low and `timeout_flag` stays high for as long as `tx_in` remains low, even if more ticks arrive. When `tx_in` returns high, the flag clears, and a later low on `tx_in` drives the bus again.
- R8: Ticks that arrive while `tx_in` is high do not advance the time-out count, and the count starts again from zero with each new low period.
- R9: Leaving normal mode clears a pending time-out and `timeout_flag`.
- R10: With `TIMEOUT_EN` = 0, `drv_on` stays high for as long as `tx_in` is low in normal mode, and `timeout_flag` is never set.
- R11: A change on `tx_in` reaches `drv_on` after exactly `SYNC_STAGES` rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse that paces the dominant time-out |
| tx_in | input | 1 | Host transmit level, asynchronous (0 = dominant request) |
| en_in | input | 1 | Host enable level, asynchronous (1 = normal mode) |
| bus_in | input | 1 | Bus comparator level (1 = recessive, 0 = dominant) |
| drv_on | output | 1 | Bus driver enable (1 = pull bus dominant) |
| rx_out | output | 1 | Receive level reported to the host |
| timeout_flag | output | 1 | High while the driver is held off by the dominant time-out |

## Verification
Some properties are checked by the assertions on every cycle. Outside normal mode the driver is off and the receive output is high. A raised time-out flag always means the driver is off. The flag can only rise in a cycle that follows one in which the driver was on, and it is gone one cycle after the block leaves normal mode. When the time-out is not built in, the flag never rises.

Other properties only the bench's scenarios can show. These are the exact tick on which the time-out fires, the fact that ticks during recessive periods are ignored, re-arming after the transmit input returns high, the synchroniser latency, and the receive path under each combination of mode and bus level.

// File: rtl/lin_tx_pkg.sv
// Shared types for the LIN transmit path controller.
// Assumes: nothing beyond IEEE 1800-2017.
package lin_tx_pkg;

    // Operating mode of the transmit path
    typedef enum logic {
        MODE_FAILSAFE = 1'b0,
        MODE_NORMAL   = 1'b1
    } lin_mode_e;

endpackage

// File: rtl/lin_sync.sv
// Multi-stage synchroniser for one asynchronous level input.
// Assumes: STAGES >= 2; the reset value matches the input's idle level.
module lin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lin_mode_ctrl.sv
// Operating mode register: fail-safe out of reset, normal while the
// synchronised enable is high.
// Assumes: en_s is already synchronous to clk.
module lin_mode_ctrl
    import lin_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_s,
    output lin_mode_e mode_q
);

    // Select the mode from the synchronised enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FAILSAFE;
        end else if (en_s) begin
            mode_q <= MODE_NORMAL;
        end else begin
            mode_q <= MODE_FAILSAFE;
        end
    end

endmodule

// File: rtl/lin_dom_timer.sv
// Dominant time-out: counts ticks while a dominant level is requested and
// latches a lock once the limit is reached. The lock holds until the
// request drops. With ENABLE = 0 the lock never sets.
// Assumes: tick is a one-cycle pulse synchronous to clk; LIMIT >= 1.
module lin_dom_timer #(
    parameter int LIMIT  = 20,
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dom_req,
    output logic locked
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    generate
        if (ENABLE) begin : g_timer
            logic [CNT_W-1:0] cnt_q;
            logic             lock_q;

            // Count ticks during a dominant request; latch at the limit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    lock_q <= 1'b0;
                end else if (!dom_req) begin
                    cnt_q  <= '0;
                    lock_q <= 1'b0;
                end else if (tick && !lock_q) begin
                    if (cnt_q == CNT_W'(LIMIT - 1)) begin
                        lock_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end

            assign locked = lock_q;
        end else begin : g_no_timer
            logic unused_inputs;
            assign unused_inputs = tick ^ dom_req ^ clk ^ rst_n;
            assign locked        = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/lin_tx_ctrl.sv
// Top of the LIN transmit path controller. It synchronises the host
// inputs, holds the operating mode, gates the driver enable by mode and
// the dominant time-out, and reports the bus level.
// Assumes: tick is a one-cycle pulse from a timebase in the clk domain.
module lin_tx_ctrl
    import lin_tx_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int TIMEOUT_TICKS = 20,
    parameter bit TIMEOUT_EN    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_in,
    input  logic en_in,
    input  logic bus_in,
    output logic drv_on,
    output logic rx_out,
    output logic timeout_flag
);

    logic      tx_s;
    logic      en_s;
    lin_mode_e mode_q;
    logic      is_normal;
    logic      dom_req;
    logic      locked;

    lin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_tx_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (tx_in),
        .q_sync  (tx_s)
    );

    lin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (en_in),
        .q_sync  (en_s)
    );

    lin_mode_ctrl u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_s   (en_s),
        .mode_q (mode_q)
    );

    // Dominant request: normal mode and transmit low
    always_comb begin
        is_normal = (mode_q == MODE_NORMAL);
        dom_req   = is_normal && !tx_s;
    end

    lin_dom_timer #(.LIMIT(TIMEOUT_TICKS), .ENABLE(TIMEOUT_EN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .dom_req (dom_req),
        .locked  (locked)
    );

    // Output gating for driver, receiver and flag
    always_comb begin
        drv_on       = dom_req && !locked;
        rx_out       = is_normal ? bus_in : 1'b1;
        timeout_flag = locked;
    end

endmodule

// File: rtl/lin_tx_ctrl_chk.sv
// Checker for the LIN transmit path controller, attached by bind.
// Assumes: is_normal is the top's decoded mode.
module lin_tx_ctrl_chk #(
    parameter bit TIMEOUT_EN = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic is_normal,
    input logic drv_on,
    input logic rx_out,
    input logic timeout_flag
);

    // R3
    failsafe_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_normal |-> !drv_on);

    // R3
    failsafe_rx_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_normal |-> rx_out);

    // R7
    lock_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |-> !drv_on);

    // R6
    timeout_from_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> $past(drv_on));

    // R9
    failsafe_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_normal |=> !timeout_flag);

    generate
        if (!TIMEOUT_EN) begin : g_free
            // R10
            no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !timeout_flag);
        end
    endgenerate

endmodule

bind lin_tx_ctrl lin_tx_ctrl_chk #(.TIMEOUT_EN(TIMEOUT_EN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .is_normal    (is_normal),
    .drv_on       (drv_on),
    .rx_out       (rx_out),
    .timeout_flag (timeout_flag)
);

// File: tb/lin_tx_ctrl_test.sv
module lin_tx_ctrl_test;

    localparam int LIMIT = 8;
    localparam int NVEC  = 8;
    // {en, tx, bus, exp_drv, exp_rx}
    localparam logic [4:0] VECS [NVEC] = '{
        5'b00101, 5'b00001, 5'b01101, 5'b10010,
        5'b10111, 5'b11000, 5'b01001, 5'b10010
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic tx_in = 1'b1;
    logic en_in = 1'b0;
    logic bus_in = 1'b1;
    logic drv_on, rx_out, timeout_flag;
    logic drv_free, rx_free, flag_free;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lin_tx_ctrl #(.SYNC_STAGES(2), .TIMEOUT_TICKS(LIMIT), .TIMEOUT_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_in(tx_in), .en_in(en_in),
        .bus_in(bus_in), .drv_on(drv_on), .rx_out(rx_out), .timeout_flag(timeout_flag)
    );

    lin_tx_ctrl #(.SYNC_STAGES(2), .TIMEOUT_TICKS(LIMIT), .TIMEOUT_EN(1'b0)) uut_free (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_in(tx_in), .en_in(en_in),
        .bus_in(bus_in), .drv_on(drv_free), .rx_out(rx_free), .timeout_flag(flag_free)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bus_in = 1'b0;
        tx_in  = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 drv", drv_on, 1'b0);
        check("R1 rx", rx_out, 1'b1);
        check("R1 flag", timeout_flag, 1'b0);

        // Vector table: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            en_in  = VECS[v][4];
            tx_in  = VECS[v][3];
            bus_in = VECS[v][2];
            wait_n(6);
            check("R2/R3/R5 drv", drv_on, VECS[v][1]);
            check("R3/R4 rx", rx_out, VECS[v][0]);
        end

        // Time-out sequence
        tx_in = 1'b1; en_in = 1'b1; bus_in = 1'b1;
        wait_n(6);
        tx_in = 1'b0;
        wait_n(5);
        pulse_ticks(LIMIT - 1);
        check("R6 before limit drv", drv_on, 1'b1);
        check("R6 before limit flag", timeout_flag, 1'b0);
        pulse_ticks(1);
        check("R6 at limit drv", drv_on, 1'b0);
        check("R6 at limit flag", timeout_flag, 1'b1);
        check("R10 free drv", drv_free, 1'b1);
        check("R10 free flag", flag_free, 1'b0);
        pulse_ticks(5);
        check("R7 held drv", drv_on, 1'b0);
        check("R7 held flag", timeout_flag, 1'b1);
        tx_in = 1'b1;
        wait_n(4);
        check("R7 rearm flag", timeout_flag, 1'b0);
        check("R7 rearm drv", drv_on, 1'b0);
        pulse_ticks(12);
        tx_in = 1'b0;
        wait_n(4);
        check("R7 drives again", drv_on, 1'b1);
        pulse_ticks(LIMIT - 1);
        check("R8 count restarted", drv_on, 1'b1);
        check("R8 flag low", timeout_flag, 1'b0);
        pulse_ticks(1);
        check("R6 second time-out", timeout_flag, 1'b1);
        en_in = 1'b0;
        wait_n(5);
        check("R9 flag cleared", timeout_flag, 1'b0);
        check("R9 drv off", drv_on, 1'b0);
        en_in = 1'b1;
        wait_n(5);
        check("R9 re-armed drv", drv_on, 1'b1);

        // R11 synchroniser latency
        tx_in = 1'b1;
        @(negedge clk);
        check("R11 after one edge", drv_on, 1'b1);
        @(negedge clk);
        check("R11 after two edges", drv_on, 1'b0);

        // R10 long dominant without time-out
        tx_in = 1'b0;
        wait_n(4);
        pulse_ticks(3 * LIMIT);
        check("R10 free long drv", drv_free, 1'b1);
        check("R10 free long flag", flag_free, 1'b0);
        check("R6 limited long drv", drv_on, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule